// File: doc/BRIEF.md
# Scanout Frame Base and Mode Selector

This block decides, once per displayed frame, where video scanout reads its pixels and how it treats them. A host writes a small set of configuration registers (mode, sync configuration, blanking control, border colour, frame size and two field base addresses). The raster generator supplies a frame pulse, the current field flag, the current line counter and the total line count. On each frame pulse the block latches a frame base address, a row stride in bytes, a line count, a pixel format code, a blank flag and a border colour. A memory fetch engine downstream uses these values. The fetch itself is not part of this block.

There are three output cases. If output is disabled, the block sends black. If output is enabled with border blanking, it sends a flat border colour. Otherwise it sends real frame data.

For interlaced scanout there are two ways to pick the base address:
- If the programmed modulo equals the line length in words, the frame is one buffer scanned at double height.
- Otherwise the block picks one of two field base addresses. It uses the field that is about to start, so it looks ahead when the raster is near retrace.

Register writes made during a frame take effect at the next frame pulse.

Register map (write address `regWrAddr`):

| Address | Contents |
|---|---|
| 0 | mode: bit 0 output enable, bits 3:2 pixel format |
| 1 | sync configuration: bit 0 video-out enable, bit 1 interlace |
| 2 | blanking control: bit 3 border blank |
| 3 | border colour, bits 24:0 |
| 4 | frame size: bits 9:0 words per line minus one, bits 19:10 lines minus one, bits 29:20 modulo plus one |
| 5 | field A base address |
| 6 | field B base address |
| 7 | unused |

Top module: `scan_frame_sel`

## Requirements
- R1: After reset, and before any frame pulse, the outputs are as follows. The blank flag is 1. The border colour, base address, stride, line count and format are all 0.
- R2: Outputs change only at a clock edge where `framePulse` is 1. At that edge they use the register values held before that edge. A register write with no frame pulse leaves every output unchanged. A write to address 7 has no effect.
- R3: Output is enabled only when mode bit 0 and sync bit 0 are both 1. When it is not enabled, the latched blank flag is 1 and the border colour is 0.
- R4: When output is enabled and blanking bit 3 is 1, the blank flag is 1. The border colour is then the last value written to address 3, masked to its low 25 bits.
- R5: When output is enabled and blanking bit 3 is 0, the blank flag is 0.
- R6: The pixel format output equals mode bits 3:2. The codes are 0 for 16-bit with 1-bit alpha, 1 for 16-bit 5-6-5, 2 for packed 24-bit and 3 for 32-bit.
- R7: Let W be size bits 9:0, L be size bits 19:10 and M be size bits 29:20. Outside the doubled case, the line count is L+1 and the stride in bytes is (W+M)×4. This is (words per line + modulo) × 4, where the modulo is M−1.
- R8: With interlace off (sync bit 1 = 0), the base address is field address A.
- R9: With interlace on and M = W+2 (modulo equal to the words per line), the base address is A, the line count is 2×(L+1) and the stride is (W+1)×4.
- R10: With interlace on and no doubling, let f be `oddField` inverted when `lineCount`+6 ≥ `totalLines`. When f is 1 the base is A; when f is 0 the base is B.
- R11: Field addresses keep only bits 23:2 of the written data. Bits 1:0 and bits above 23 read as 0 in the base address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regWrAddr | input | 3 | Register index |
| regWrData | input | 32 | Register write data |
| framePulse | input | 1 | One-cycle frame start from the raster generator |
| oddField | input | 1 | Current field flag, 1 = odd |
| lineCount | input | 10 | Current raster line |
| totalLines | input | 10 | Lines per frame |
| baseAddr | output | 24 | Latched frame base address |
| strideBytes | output | 13 | Latched row stride in bytes |
| frameLines | output | 12 | Latched number of lines to scan |
| pixFmt | output | 2 | Latched pixel format code |
| blankOut | output | 1 | 1 when black or border colour is sent |
| borderColour | output | 25 | Latched border colour, 0 when disabled |

## Verification
The assertions assume two things:
- `framePulse` is the only event that moves the latched outputs.
- The raster inputs are stable across the edge where the pulse is sampled.

The bench drives the register port and every raster input half a cycle away from the clock edge, and it raises `framePulse` for exactly one cycle. It also assumes that `lineCount` stays below `totalLines`. The stimulus keeps to that by using a 525-line frame with line numbers in range, including the lines on both sides of the retrace look-ahead threshold.

// File: rtl/scan_pkg.sv
package scan_pkg;

  localparam int REG_AW = 3;

  localparam logic [REG_AW-1:0] IDX_MODE   = 3'd0;
  localparam logic [REG_AW-1:0] IDX_SYNC   = 3'd1;
  localparam logic [REG_AW-1:0] IDX_BLANK  = 3'd2;
  localparam logic [REG_AW-1:0] IDX_BORDER = 3'd3;
  localparam logic [REG_AW-1:0] IDX_SIZE   = 3'd4;
  localparam logic [REG_AW-1:0] IDX_FLDA   = 3'd5;
  localparam logic [REG_AW-1:0] IDX_FLDB   = 3'd6;

  localparam int MODE_EN_BIT     = 0;
  localparam int MODE_FMT_LSB    = 2;
  localparam int SYNC_VOUT_BIT   = 0;
  localparam int SYNC_ILACE_BIT  = 1;
  localparam int BLANK_BORDER_BIT = 3;

  // Lines from the frame pulse to the end of a field at which the
  // upcoming field is chosen instead of the current one.
  localparam int LOOKAHEAD_LINES = 6;

  typedef enum logic [1:0] {
    FMT_ARGB1555 = 2'd0,
    FMT_RGB565   = 2'd1,
    FMT_RGB888   = 2'd2,
    FMT_ARGB8888 = 2'd3
  } pix_fmt_e;

  typedef struct packed {
    logic wrMode;
    logic wrSync;
    logic wrBlank;
    logic wrBorder;
    logic wrSize;
    logic wrFldA;
    logic wrFldB;
    logic latch;
  } scan_strobe_t;

endpackage

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import scan_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regWrAddr,
  input  logic              framePulse,
  output scan_strobe_t      strobes
);

  always_comb begin
    strobes          = '0;
    strobes.latch    = framePulse;
    if (regWrEn) begin
      unique case (regWrAddr)
        IDX_MODE:   strobes.wrMode   = 1'b1;
        IDX_SYNC:   strobes.wrSync   = 1'b1;
        IDX_BLANK:  strobes.wrBlank  = 1'b1;
        IDX_BORDER: strobes.wrBorder = 1'b1;
        IDX_SIZE:   strobes.wrSize   = 1'b1;
        IDX_FLDA:   strobes.wrFldA   = 1'b1;
        IDX_FLDB:   strobes.wrFldB   = 1'b1;
        default:    ;
      endcase
    end
  end

  logic [6:0] wrVec;
  assign wrVec = {strobes.wrMode, strobes.wrSync, strobes.wrBlank,
                  strobes.wrBorder, strobes.wrSize, strobes.wrFldA,
                  strobes.wrFldB};

  // R2: at most one register is written per cycle
  a_r2_one_write: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(wrVec));

  // R2: no write strobe without a port write; address 7 writes nothing
  a_r2_idle_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (!regWrEn || regWrAddr == 3'd7) |-> (wrVec == 7'd0));

  // R2: latching follows the raster pulse only
  a_r2_latch_src: assert property (@(posedge clk) disable iff (!rstN)
    strobes.latch == framePulse);

endmodule

// File: rtl/scan_dp.sv
module scan_dp
  import scan_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 24,
  parameter int LINE_W   = 10,
  parameter int BORDER_W = 25,
  localparam int STRIDE_W = LINE_W + 3,
  localparam int LINES_W  = LINE_W + 2,
  localparam int SIZE_W   = 3 * LINE_W,
  localparam int FADDR_W  = ADDR_W - 2
)(
  input  logic                clk,
  input  logic                rstN,
  input  scan_strobe_t        strobes,
  input  logic [DATA_W-1:0]   wrData,
  input  logic                oddField,
  input  logic [LINE_W-1:0]   lineCount,
  input  logic [LINE_W-1:0]   totalLines,
  output logic [ADDR_W-1:0]   baseAddr,
  output logic [STRIDE_W-1:0] strideBytes,
  output logic [LINES_W-1:0]  frameLines,
  output logic [1:0]          pixFmt,
  output logic                blankOut,
  output logic [BORDER_W-1:0] borderColour
);

  // ---------------- configuration registers ----------------
  logic                modeEn;
  logic [1:0]          modeFmt;
  logic                syncVout;
  logic                syncIlace;
  logic                blankBorder;
  logic [BORDER_W-1:0] borderReg;
  logic [SIZE_W-1:0]   sizeReg;
  logic [FADDR_W-1:0]  fldAReg;
  logic [FADDR_W-1:0]  fldBReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeEn      <= 1'b0;
      modeFmt     <= 2'd0;
      syncVout    <= 1'b0;
      syncIlace   <= 1'b0;
      blankBorder <= 1'b0;
      borderReg   <= '0;
      sizeReg     <= '0;
      fldAReg     <= '0;
      fldBReg     <= '0;
    end else begin
      if (strobes.wrMode) begin
        modeEn  <= wrData[MODE_EN_BIT];
        modeFmt <= wrData[MODE_FMT_LSB +: 2];
      end
      if (strobes.wrSync) begin
        syncVout  <= wrData[SYNC_VOUT_BIT];
        syncIlace <= wrData[SYNC_ILACE_BIT];
      end
      if (strobes.wrBlank)  blankBorder <= wrData[BLANK_BORDER_BIT];
      if (strobes.wrBorder) borderReg   <= wrData[BORDER_W-1:0];
      if (strobes.wrSize)   sizeReg     <= wrData[SIZE_W-1:0];
      if (strobes.wrFldA)   fldAReg     <= wrData[ADDR_W-1:2];
      if (strobes.wrFldB)   fldBReg     <= wrData[ADDR_W-1:2];
    end
  end

  logic unusedWrBits;
  assign unusedWrBits = ^{wrData[DATA_W-1:SIZE_W], wrData[1], wrData[BLANK_BORDER_BIT-1:2]};

  // ---------------- next-frame computation ----------------
  logic [LINE_W-1:0] wordsM1, linesM1, modP1;
  assign wordsM1 = sizeReg[0 +: LINE_W];
  assign linesM1 = sizeReg[LINE_W +: LINE_W];
  assign modP1   = sizeReg[2*LINE_W +: LINE_W];

  logic [LINE_W:0] wordsP1, linesP1, strideWords;
  assign wordsP1     = {1'b0, wordsM1} + (LINE_W+1)'(1);
  assign linesP1     = {1'b0, linesM1} + (LINE_W+1)'(1);
  assign strideWords = {1'b0, wordsM1} + {1'b0, modP1};

  logic outEnabled, doubleScan, nearRetrace, pickOdd;
  assign outEnabled  = modeEn & syncVout;
  assign doubleScan  = syncIlace &&
                       ({1'b0, modP1} == ({1'b0, wordsM1} + (LINE_W+1)'(2)));
  assign nearRetrace = ({1'b0, lineCount} + (LINE_W+1)'(LOOKAHEAD_LINES))
                       >= {1'b0, totalLines};
  assign pickOdd     = oddField ^ nearRetrace;

  logic [ADDR_W-1:0]   nxtBase;
  logic [STRIDE_W-1:0] nxtStride;
  logic [LINES_W-1:0]  nxtLines;
  logic                nxtBlank;
  logic [BORDER_W-1:0] nxtBorder;

  always_comb begin
    nxtStride = {strideWords, 2'b00};
    nxtLines  = {1'b0, linesP1};
    nxtBase   = {fldAReg, 2'b00};
    if (doubleScan) begin
      nxtStride = {wordsP1, 2'b00};
      nxtLines  = {linesP1, 1'b0};
    end else if (syncIlace && !pickOdd) begin
      nxtBase   = {fldBReg, 2'b00};
    end
    nxtBlank  = !outEnabled || blankBorder;
    nxtBorder = outEnabled ? borderReg : '0;
  end

  // ---------------- per-frame output latch ----------------
  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseAddr     <= '0;
      strideBytes  <= '0;
      frameLines   <= '0;
      pixFmt       <= 2'd0;
      blankOut     <= 1'b1;
      borderColour <= '0;
    end else if (strobes.latch) begin
      baseAddr     <= nxtBase;
      strideBytes  <= nxtStride;
      frameLines   <= nxtLines;
      pixFmt       <= modeFmt;
      blankOut     <= nxtBlank;
      borderColour <= nxtBorder;
    end
  end

  // ---------------- assertions ----------------
  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.latch |=> ($stable(baseAddr) && $stable(strideBytes) &&
                        $stable(frameLines) && $stable(pixFmt) &&
                        $stable(blankOut) && $stable(borderColour)));

  a_r3_disabled_black: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.latch && !(modeEn && syncVout)) |=> (blankOut && borderColour == '0));

  a_r4_border_out: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.latch && modeEn && syncVout && blankBorder)
      |=> (blankOut && borderColour == $past(borderReg)));

  a_r5_live_out: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.latch && modeEn && syncVout && !blankBorder) |=> !blankOut);

  a_r6_format: assert property (@(posedge clk) disable iff (!rstN)
    strobes.latch |=> pixFmt == $past(modeFmt));

  a_r8_progressive_base: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.latch && !syncIlace) |=> baseAddr[ADDR_W-1:2] == $past(fldAReg));

  a_r11_aligned: assert property (@(posedge clk) disable iff (!rstN)
    strobes.latch |=> baseAddr[1:0] == 2'b00);

endmodule

// File: rtl/scan_frame_sel.sv
module scan_frame_sel
  import scan_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 24,
  parameter int LINE_W   = 10,
  parameter int BORDER_W = 25,
  localparam int STRIDE_W = LINE_W + 3,
  localparam int LINES_W  = LINE_W + 2
)(
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [REG_AW-1:0]   regWrAddr,
  input  logic [DATA_W-1:0]   regWrData,
  input  logic                framePulse,
  input  logic                oddField,
  input  logic [LINE_W-1:0]   lineCount,
  input  logic [LINE_W-1:0]   totalLines,
  output logic [ADDR_W-1:0]   baseAddr,
  output logic [STRIDE_W-1:0] strideBytes,
  output logic [LINES_W-1:0]  frameLines,
  output logic [1:0]          pixFmt,
  output logic                blankOut,
  output logic [BORDER_W-1:0] borderColour
);

  scan_strobe_t strobes;

  scan_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regWrAddr  (regWrAddr),
    .framePulse (framePulse),
    .strobes    (strobes)
  );

  scan_dp #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .LINE_W   (LINE_W),
    .BORDER_W (BORDER_W)
  ) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .wrData       (regWrData),
    .oddField     (oddField),
    .lineCount    (lineCount),
    .totalLines   (totalLines),
    .baseAddr     (baseAddr),
    .strideBytes  (strideBytes),
    .frameLines   (frameLines),
    .pixFmt       (pixFmt),
    .blankOut     (blankOut),
    .borderColour (borderColour)
  );

endmodule

// File: tb/scan_frame_sel_tb.sv
module scan_frame_sel_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regWrAddr = '0;
  logic [31:0] regWrData = '0;
  logic        framePulse = 1'b0;
  logic        oddField = 1'b0;
  logic [9:0]  lineCount = '0;
  logic [9:0]  totalLines = 10'd525;
  logic [23:0] baseAddr;
  logic [12:0] strideBytes;
  logic [11:0] frameLines;
  logic [1:0]  pixFmt;
  logic        blankOut;
  logic [24:0] borderColour;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  scan_frame_sel dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrAddr(regWrAddr),
    .regWrData(regWrData), .framePulse(framePulse), .oddField(oddField),
    .lineCount(lineCount), .totalLines(totalLines), .baseAddr(baseAddr),
    .strideBytes(strideBytes), .frameLines(frameLines), .pixFmt(pixFmt),
    .blankOut(blankOut), .borderColour(borderColour)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regWrAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic frame();
    @(negedge clk);
    framePulse = 1'b1;
    @(negedge clk);
    framePulse = 1'b0;
  endtask

  task automatic expect_all(input string req, input logic [23:0] b,
                            input logic [12:0] s, input logic [11:0] l,
                            input logic [1:0] f, input logic bl,
                            input logic [24:0] bc);
    chk(req, "base",   32'(baseAddr),     32'(b));
    chk(req, "stride", 32'(strideBytes),  32'(s));
    chk(req, "lines",  32'(frameLines),   32'(l));
    chk(req, "fmt",    32'(pixFmt),       32'(f));
    chk(req, "blank",  32'(blankOut),     32'(bl));
    chk(req, "border", 32'(borderColour), 32'(bc));
  endtask

  // size word: W bits 9:0, L bits 19:10, M bits 29:20
  function automatic logic [31:0] sz(input int w, input int l, input int m);
    return 32'((m << 20) | (l << 10) | w);
  endfunction

  task automatic t_reset();
    @(negedge clk);
    expect_all("R1", 24'h0, 13'd0, 12'd0, 2'd0, 1'b1, 25'd0);
  endtask

  task automatic t_progressive();
    wr(3'd0, 32'h5);                 // enable, format 1
    wr(3'd1, 32'h1);                 // video out, progressive
    wr(3'd4, sz(319, 239, 1));
    wr(3'd5, 32'h1234_5677);
    wr(3'd6, 32'h0000_1000);
    wr(3'd3, 32'h0000_00AB);
    // R2: no frame pulse yet, still reset values
    @(negedge clk);
    expect_all("R2", 24'h0, 13'd0, 12'd0, 2'd0, 1'b1, 25'd0);
    frame();
    // R7 stride (319+1)*4, R8 field A, R11 masking, R5 not blank
    expect_all("R8", 24'h345674, 13'd1280, 12'd240, 2'd1, 1'b0, 25'hAB);
  endtask

  task automatic t_formats();
    for (int f = 0; f < 4; f++) begin
      wr(3'd0, 32'(1 | (f << 2)));
      frame();
      chk("R6", "fmt sweep", 32'(pixFmt), 32'(f));
    end
    wr(3'd4, sz(100, 50, 7));        // R7: stride (100+7)*4
    frame();
    chk("R7", "stride", 32'(strideBytes), 32'd428);
    chk("R7", "lines",  32'(frameLines),  32'd51);
  endtask

  task automatic t_disabled();
    wr(3'd1, 32'h0);                 // video out off
    frame();
    chk("R3", "blank vout off",  32'(blankOut),     32'd1);
    chk("R3", "border vout off", 32'(borderColour), 32'd0);
    wr(3'd1, 32'h1);
    wr(3'd0, 32'h0);                 // mode enable off
    frame();
    chk("R3", "blank mode off",  32'(blankOut),     32'd1);
    chk("R3", "border mode off", 32'(borderColour), 32'd0);
    wr(3'd0, 32'h1);
    frame();
    chk("R5", "live again", 32'(blankOut), 32'd0);
  endtask

  task automatic t_border();
    wr(3'd3, 32'hFFFF_FFFF);
    wr(3'd2, 32'h8);
    frame();
    chk("R4", "blank",  32'(blankOut),     32'd1);
    chk("R4", "border", 32'(borderColour), 32'h01FF_FFFF);
    wr(3'd2, 32'h0);
    frame();
    chk("R5", "border cleared", 32'(blankOut), 32'd0);
  endtask

  task automatic t_double();
    wr(3'd1, 32'h3);                 // interlaced
    wr(3'd5, 32'hFFFF_FFFF);         // R11: becomes 0xFFFFFC
    wr(3'd6, 32'h0022_0000);
    wr(3'd4, sz(9, 99, 11));         // M = W+2
    oddField = 1'b0; lineCount = 10'd100;
    frame();
    expect_all("R9", 24'hFFFFFC, 13'd40, 12'd200, 2'd0, 1'b0, 25'h1FFFFFF);
  endtask

  task automatic t_fields();
    wr(3'd4, sz(9, 99, 1));
    oddField = 1'b1; lineCount = 10'd100; frame();
    chk("R10", "odd mid",  32'(baseAddr), 32'hFFFFFC);
    chk("R10", "stride",   32'(strideBytes), 32'd40);
    oddField = 1'b0; lineCount = 10'd100; frame();
    chk("R10", "even mid", 32'(baseAddr), 32'h220000);
    oddField = 1'b0; lineCount = 10'd518; frame();
    chk("R10", "even 518", 32'(baseAddr), 32'h220000);
    oddField = 1'b1; lineCount = 10'd519; frame();
    chk("R10", "odd 519 lookahead", 32'(baseAddr), 32'h220000);
    oddField = 1'b0; lineCount = 10'd520; frame();
    chk("R10", "even 520 lookahead", 32'(baseAddr), 32'hFFFFFC);
  endtask

  task automatic t_hold();
    // R2: writes without a pulse, including address 7, change nothing
    wr(3'd5, 32'h0000_0400);
    wr(3'd0, 32'hC);
    wr(3'd7, 32'hFFFF_FFFF);
    @(negedge clk);
    chk("R2", "base held", 32'(baseAddr), 32'hFFFFFC);
    chk("R2", "fmt held",  32'(pixFmt),   32'd0);
    chk("R2", "blank held", 32'(blankOut), 32'd0);
    oddField = 1'b1; lineCount = 10'd10;
    frame();
    chk("R2", "new base after pulse", 32'(baseAddr), 32'h000400);
    chk("R3", "mode off after pulse", 32'(blankOut), 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_progressive();
    t_formats();
    t_disabled();
    t_border();
    t_double();
    t_fields();
    t_hold();
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule